// File: doc/BRIEF.md
# Prioritized Chip Select Decoder

This block turns each CPU bus access into at most one of four active-low chip-select strobes. Every output owns a programmable address window (base plus mask), a direction qualifier and a data-bus width flag. The windows are compared in parallel, and the lowest-numbered matching output wins. The selected output, its width and any bus error respond in the same cycle as the address. When two windows claim one access, or a write lands on a read-only window, the block raises sticky status flags. Each kind of event can also raise a bus error, gated by its own enable.

Software programs the block through a simple indexed register write port. Index 2i holds window i's base and valid bit. Index 2i+1 holds its mask, direction field and width flag. Index 8 holds the control and status bits, and index 9 holds the base of the control-register block. Accesses that fall inside the control-register block never select an external device.

A cold reset leaves output 0 open over the bottom 8 KB, so a boot ROM can be fetched. Its width is taken from a strap input during reset. Output 3 can act as the window of an 8-bit legacy bus, which drives its own read, write and address-latch strobes.

There is no state sequencer. Decode is purely combinational, and the only storage is the configuration and the two sticky flags.

Top module: `prio_cs_decoder`

## Requirements
- R1: When several windows select an access, only the lowest-numbered of those outputs asserts (low), and at most one `cs_n` bit is ever low.
- R2: An access matched by two or more valid windows sets `flag_conf`. The flag holds until a control write (index 8) with bit 8 set clears it. A new event in the same cycle wins over the clear.
- R3: `berr` is high for a conflicting access only when control bit 0 is 1. It is high for a write-protect violation only when control bit 1 is 1. Otherwise it stays low.
- R4: A read-only window (direction 01) and a write-only window (direction 10) that match the same access are not a conflict.
- R5: A write matched by a read-only window does not assert that window's output. If no other window accepts the write, `flag_wpv` is set; it is cleared by control bit 9 written as 1. A read matched by a write-only window asserts nothing and sets no flag.
- R6: An access inside the control-register block asserts no output, no `berr` and no flag, even when a window covers it. The block is 4 KB aligned; its base is written at index 9 and resets to 0xFFF000.
- R7: After cold reset, output 0 is valid, read/write, with base 0 and a mask covering the bottom 8 KB. Its width (`bus_wide`, 1 = 16-bit) equals the `strap_wide` level present during reset.
- R8: After cold reset, outputs 1 to 3 are invalid and never assert.
- R9: With control bit 2 set, accesses selected by output 3 drive `leg_ale` high, and drive `leg_rd_n` low for reads or `leg_wr_n` low for writes, at forced 8-bit width. With bit 2 clear, `leg_rd_n` and `leg_wr_n` stay high and `leg_ale` stays low.
- R10: Window i matches when `((bus_addr ^ base) & mask) == 0` and its valid bit is set. The base/valid word is data[23:0] for the base and data[31] for valid. The mask word is data[23:0] for the mask, data[31:30] for direction (00 and 11 both directions, 01 read-only, 10 write-only) and data[29] for width.
- R11: `cs_n`, `bus_wide`, `berr` and the legacy strobes follow the bus inputs in the same cycle. With `bus_vld` low, all outputs are negated and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, synchronous |
| strap_wide | input | 1 | Boot window width strap, sampled during reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| bus_vld | input | 1 | Bus access valid |
| bus_addr | input | 24 | Bus address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| cs_n | output | 4 | Chip selects, active low |
| bus_wide | output | 1 | Width of the selected device, 1 = 16-bit |
| berr | output | 1 | Bus error |
| flag_conf | output | 1 | Sticky decode-conflict flag |
| flag_wpv | output | 1 | Sticky write-protect flag |
| leg_rd_n | output | 1 | Legacy bus read strobe, active low |
| leg_wr_n | output | 1 | Legacy bus write strobe, active low |
| leg_ale | output | 1 | Legacy bus address latch enable |

## Verification
The assertions assume that `bus_rd` and `bus_addr` are settled whenever `bus_vld` is high. They also assume that a control write does not clear a flag in the same cycle that a new event would set it. The stimulus changes the bus and configuration inputs only just after a rising edge. It keeps clears and flag-raising accesses in separate cycles. It never drives an unknown value once reset has been released.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;
    typedef enum logic [1:0] {
        ACC_BOTH     = 2'b00,
        ACC_RD_ONLY  = 2'b01,
        ACC_WR_ONLY  = 2'b10,
        ACC_BOTH_ALT = 2'b11
    } acc_e;

    typedef struct packed {
        logic valid;
        acc_e acc;
        logic wide;
    } win_attr_t;

    localparam int CTRL_CONF_EN  = 0;
    localparam int CTRL_WP_EN    = 1;
    localparam int CTRL_LEG_EN   = 2;
    localparam int CTRL_CLR_CONF = 8;
    localparam int CTRL_CLR_WPV  = 9;
    localparam int WORD_VALID    = 31;
    localparam int WORD_ACC_HI   = 31;
    localparam int WORD_ACC_LO   = 30;
    localparam int WORD_WIDE     = 29;
endpackage

// File: rtl/csd_window_match.sv
`timescale 1ns/1ps
module csd_window_match
    import csd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  win_attr_t         attr,
    input  logic              rd,
    input  logic              qual,
    output logic              hit,
    output logic              dir_ok,
    output logic              is_ro,
    output logic              is_wo
);
    always_comb begin
        hit    = qual && attr.valid && (((addr ^ base) & mask) == '0);
        is_ro  = (attr.acc == ACC_RD_ONLY);
        is_wo  = (attr.acc == ACC_WR_ONLY);
        dir_ok = !(is_ro && !rd) && !(is_wo && rd);
    end
endmodule

// File: rtl/csd_priority.sv
`timescale 1ns/1ps
module csd_priority #(
    parameter int NCS = 4
) (
    input  logic [NCS-1:0] hit,
    input  logic [NCS-1:0] dir_ok,
    input  logic [NCS-1:0] is_ro,
    input  logic [NCS-1:0] is_wo,
    input  logic           rd,
    output logic [NCS-1:0] sel,
    output logic           conflict,
    output logic           wp_viol
);
    logic found;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < NCS; i++) begin
            if (!found && hit[i] && dir_ok[i]) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    always_comb begin
        conflict = 1'b0;
        for (int i = 0; i < NCS; i++) begin
            for (int j = i + 1; j < NCS; j++) begin
                if (hit[i] && hit[j] &&
                    !((is_ro[i] && is_wo[j]) || (is_wo[i] && is_ro[j])))
                    conflict = 1'b1;
            end
        end
    end

    always_comb wp_viol = !rd && !found && |(hit & is_ro);
endmodule

// File: rtl/csd_regs.sv
`timescale 1ns/1ps
module csd_regs
    import csd_pkg::*;
#(
    parameter int          ADDR_W     = 24,
    parameter int          NCS        = 4,
    parameter int          BOOT_BYTES = 8192,
    parameter int unsigned BLK_RESET  = 32'h00FF_F000,
    localparam int         IDX_W      = $clog2(2*NCS + 2)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         strap_wide,
    input  logic                         cfg_we,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic [31:0]                  cfg_wdata,
    input  logic                         evt_conf,
    input  logic                         evt_wpv,
    output logic [NCS-1:0][ADDR_W-1:0]   win_base,
    output logic [NCS-1:0][ADDR_W-1:0]   win_mask,
    output win_attr_t [NCS-1:0]          win_attr,
    output logic                         en_conf,
    output logic                         en_wp,
    output logic                         leg_en,
    output logic                         flag_conf,
    output logic                         flag_wpv,
    output logic [ADDR_W-1:0]            blk_base
);
    localparam int              BOOT_LG   = $clog2(BOOT_BYTES);
    localparam logic [ADDR_W-1:0] BOOT_MASK = {ADDR_W{1'b1}} << BOOT_LG;
    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(2*NCS);
    localparam logic [IDX_W-1:0] IDX_BLK  = IDX_W'(2*NCS + 1);

    logic ctrl_wr, clr_conf, clr_wpv;
    logic unused_wdata;

    assign unused_wdata = ^cfg_wdata;
    assign ctrl_wr  = cfg_we && (cfg_idx == IDX_CTRL);
    assign clr_conf = ctrl_wr && cfg_wdata[CTRL_CLR_CONF];
    assign clr_wpv  = ctrl_wr && cfg_wdata[CTRL_CLR_WPV];

    for (genvar i = 0; i < NCS; i++) begin : g_win
        localparam bit IS_BOOT = (i == 0);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_base[i]       <= '0;
                win_mask[i]       <= IS_BOOT ? BOOT_MASK : '0;
                win_attr[i].valid <= IS_BOOT;
                win_attr[i].acc   <= ACC_BOTH;
                win_attr[i].wide  <= IS_BOOT ? strap_wide : 1'b0;
            end else if (cfg_we && cfg_idx == IDX_W'(2*i)) begin
                win_base[i]       <= cfg_wdata[ADDR_W-1:0];
                win_attr[i].valid <= cfg_wdata[WORD_VALID];
            end else if (cfg_we && cfg_idx == IDX_W'(2*i + 1)) begin
                win_mask[i]       <= cfg_wdata[ADDR_W-1:0];
                win_attr[i].acc   <= acc_e'(cfg_wdata[WORD_ACC_HI:WORD_ACC_LO]);
                win_attr[i].wide  <= cfg_wdata[WORD_WIDE];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_conf   <= 1'b0;
            en_wp     <= 1'b0;
            leg_en    <= 1'b0;
            flag_conf <= 1'b0;
            flag_wpv  <= 1'b0;
            blk_base  <= ADDR_W'(BLK_RESET);
        end else begin
            if (ctrl_wr) begin
                en_conf <= cfg_wdata[CTRL_CONF_EN];
                en_wp   <= cfg_wdata[CTRL_WP_EN];
                leg_en  <= cfg_wdata[CTRL_LEG_EN];
            end
            if (cfg_we && cfg_idx == IDX_BLK)
                blk_base <= cfg_wdata[ADDR_W-1:0];
            flag_conf <= evt_conf || (flag_conf && !clr_conf);
            flag_wpv  <= evt_wpv  || (flag_wpv  && !clr_wpv);
        end
    end

    AST_CONF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_conf && !clr_conf) |=> flag_conf);  // R2
    AST_WPV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wpv && !clr_wpv) |=> flag_wpv);  // R5
endmodule

// File: rtl/prio_cs_decoder.sv
`timescale 1ns/1ps
module prio_cs_decoder
    import csd_pkg::*;
#(
    parameter int          ADDR_W     = 24,
    parameter int          NCS        = 4,
    parameter int          BOOT_BYTES = 8192,
    parameter int          BLK_BYTES  = 4096,
    parameter int unsigned BLK_RESET  = 32'h00FF_F000,
    localparam int         IDX_W      = $clog2(2*NCS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_wide,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              bus_vld,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic [NCS-1:0]    cs_n,
    output logic              bus_wide,
    output logic              berr,
    output logic              flag_conf,
    output logic              flag_wpv,
    output logic              leg_rd_n,
    output logic              leg_wr_n,
    output logic              leg_ale
);
    localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} << $clog2(BLK_BYTES);

    logic [NCS-1:0][ADDR_W-1:0] win_base, win_mask;
    win_attr_t [NCS-1:0]        win_attr;
    logic [NCS-1:0]             hit, dir_ok, is_ro, is_wo, sel;
    logic [ADDR_W-1:0]          blk_base;
    logic en_conf, en_wp, leg_en, conflict, wp_viol, in_blk, qual, leg_sel;

    csd_regs #(
        .ADDR_W(ADDR_W), .NCS(NCS), .BOOT_BYTES(BOOT_BYTES), .BLK_RESET(BLK_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_wide(strap_wide),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .evt_conf(conflict), .evt_wpv(wp_viol),
        .win_base(win_base), .win_mask(win_mask), .win_attr(win_attr),
        .en_conf(en_conf), .en_wp(en_wp), .leg_en(leg_en),
        .flag_conf(flag_conf), .flag_wpv(flag_wpv), .blk_base(blk_base)
    );

    assign in_blk = (((bus_addr ^ blk_base) & BLK_MASK) == '0);
    assign qual   = bus_vld && !in_blk;

    for (genvar i = 0; i < NCS; i++) begin : g_match
        csd_window_match #(.ADDR_W(ADDR_W)) u_match (
            .addr(bus_addr), .base(win_base[i]), .mask(win_mask[i]),
            .attr(win_attr[i]), .rd(bus_rd), .qual(qual),
            .hit(hit[i]), .dir_ok(dir_ok[i]), .is_ro(is_ro[i]), .is_wo(is_wo[i])
        );
        AST_NO_WR_TO_RO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_vld && !bus_rd && !cs_n[i]) |-> (win_attr[i].acc != ACC_RD_ONLY));  // R5
    end

    csd_priority #(.NCS(NCS)) u_prio (
        .hit(hit), .dir_ok(dir_ok), .is_ro(is_ro), .is_wo(is_wo), .rd(bus_rd),
        .sel(sel), .conflict(conflict), .wp_viol(wp_viol)
    );

    always_comb begin
        cs_n     = ~sel;
        bus_wide = 1'b0;
        for (int i = 0; i < NCS; i++) begin
            if (sel[i])
                bus_wide = win_attr[i].wide && !((i == NCS - 1) && leg_en);
        end
        berr     = (conflict && en_conf) || (wp_viol && en_wp);
        leg_sel  = leg_en && sel[NCS-1];
        leg_ale  = leg_sel;
        leg_rd_n = !(leg_sel && bus_rd);
        leg_wr_n = !(leg_sel && !bus_rd);
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));  // R1
    AST_BLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && in_blk) |-> ((&cs_n) && !berr));  // R6
    AST_LEG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !leg_en |-> (leg_rd_n && leg_wr_n && !leg_ale));  // R9
    AST_BERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        berr |=> (flag_conf || flag_wpv));  // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_vld |-> ((&cs_n) && !berr && !leg_ale));  // R11
endmodule

// File: tb/sim_prio_cs_decoder.sv
`timescale 1ns/1ps
module sim_prio_cs_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_wide = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_vld = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_rd = 1'b1;
    logic [3:0]  cs_n;
    logic        bus_wide, berr, flag_conf, flag_wpv, leg_rd_n, leg_wr_n, leg_ale;

    always #2.5 clk = ~clk;

    prio_cs_decoder u0 (
        .clk(clk), .rst_n(rst_n), .strap_wide(strap_wide),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .bus_vld(bus_vld), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .cs_n(cs_n), .bus_wide(bus_wide), .berr(berr),
        .flag_conf(flag_conf), .flag_wpv(flag_wpv),
        .leg_rd_n(leg_rd_n), .leg_wr_n(leg_wr_n), .leg_ale(leg_ale)
    );

    // behavioural reference state
    logic [23:0] m_base [4];
    logic [23:0] m_mask [4];
    int          m_valid [4];
    int          m_acc [4];
    int          m_wide [4];
    int          m_en_c, m_en_w, m_leg, m_fc, m_fw;
    logic [23:0] m_blk;

    int    n_chk = 0, n_fail = 0;
    bit    chk_on = 1'b0, finished = 1'b0;
    string cur_req = "R7";

    // returns {conflict, wpv, cs_n[3:0], wide, berr, fc, fw, rd_n, wr_n, ale}
    function automatic logic [12:0] model_eval();
        int  hits [4];
        int  sel = -1;
        int  conf = 0, wpv = 0, ro_hit = 0, ok;
        bit  inblk;
        logic [3:0] csv = 4'hF;
        logic wide = 1'b0, be, lsel;
        inblk = ((bus_addr & 24'hFFF000) == (m_blk & 24'hFFF000));
        for (int i = 0; i < 4; i++) begin
            hits[i] = (bus_vld && !inblk && m_valid[i] != 0 &&
                       ((bus_addr ^ m_base[i]) & m_mask[i]) == 24'h0) ? 1 : 0;
            ok = (m_acc[i] == 1) ? (bus_rd ? 1 : 0) :
                 (m_acc[i] == 2) ? (bus_rd ? 0 : 1) : 1;
            if (hits[i] != 0 && m_acc[i] == 1) ro_hit = 1;
            if (sel < 0 && hits[i] != 0 && ok != 0) sel = i;
        end
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                if (i != j && hits[i] != 0 && hits[j] != 0 &&
                    !(m_acc[i] == 1 && m_acc[j] == 2) && !(m_acc[i] == 2 && m_acc[j] == 1))
                    conf = 1;
        if (!bus_rd && sel < 0 && ro_hit != 0) wpv = 1;
        if (sel >= 0) begin
            csv[sel] = 1'b0;
            wide = (sel == 3 && m_leg != 0) ? 1'b0 : (m_wide[sel] != 0);
        end
        be   = (conf != 0 && m_en_c != 0) || (wpv != 0 && m_en_w != 0);
        lsel = (m_leg != 0 && sel == 3);
        return {conf[0], wpv[0], csv, wide, be, m_fc[0], m_fw[0],
                !(lsel && bus_rd), !(lsel && !bus_rd), lsel};
    endfunction

    always @(posedge clk) begin
        logic [12:0] e;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_base[i] = 24'h0; m_mask[i] = 24'h0;
                m_valid[i] = 0; m_acc[i] = 0; m_wide[i] = 0;
            end
            m_mask[0] = 24'hFFE000; m_valid[0] = 1; m_wide[0] = strap_wide ? 1 : 0;
            m_en_c = 0; m_en_w = 0; m_leg = 0; m_fc = 0; m_fw = 0;
            m_blk = 24'hFFF000;
        end else begin
            e = model_eval();
            if (cfg_we && cfg_idx == 4'd8) begin
                if (cfg_wdata[8]) m_fc = 0;
                if (cfg_wdata[9]) m_fw = 0;
                m_en_c = cfg_wdata[0] ? 1 : 0;
                m_en_w = cfg_wdata[1] ? 1 : 0;
                m_leg  = cfg_wdata[2] ? 1 : 0;
            end
            if (e[12]) m_fc = 1;
            if (e[11]) m_fw = 1;
            if (cfg_we && cfg_idx < 4'd8) begin
                if (cfg_idx[0] == 1'b0) begin
                    m_base[cfg_idx[2:1]]  = cfg_wdata[23:0];
                    m_valid[cfg_idx[2:1]] = cfg_wdata[31] ? 1 : 0;
                end else begin
                    m_mask[cfg_idx[2:1]] = cfg_wdata[23:0];
                    m_acc[cfg_idx[2:1]]  = int'(cfg_wdata[31:30]);
                    m_wide[cfg_idx[2:1]] = cfg_wdata[29] ? 1 : 0;
                end
            end
            if (cfg_we && cfg_idx == 4'd9) m_blk = cfg_wdata[23:0];
        end
    end

    always @(negedge clk) begin
        logic [12:0] e;
        logic [10:0] act;
        if (chk_on && !finished) begin
            e   = model_eval();
            act = {cs_n, bus_wide, berr, flag_conf, flag_wpv, leg_rd_n, leg_wr_n, leg_ale};
            n_chk++;
            if (act !== e[10:0]) begin
                n_fail++;
                $display("FAIL %s at %0t addr=%h rd=%b: act cs_n/wide/berr/fc/fw/rdn/wrn/ale=%b exp=%b",
                         cur_req, $time, bus_addr, bus_rd, act, e[10:0]);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset(input logic strap);
        chk_on = 1'b0;
        rst_n = 1'b0; strap_wide = strap; bus_vld = 1'b0; cfg_we = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        chk_on = 1'b1;
    endtask

    task automatic wcfg(input logic [3:0] idx, input logic [31:0] d);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic acc(input logic [23:0] a, input logic rd);
        bus_vld = 1'b1; bus_addr = a; bus_rd = rd;
        tick();
        bus_vld = 1'b0;
    endtask

    initial begin
        #(150000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        cur_req = "R7 boot window strap low";
        acc(24'h000000, 1'b1); acc(24'h001FFF, 1'b1); acc(24'h000100, 1'b0);
        cur_req = "R8 other outputs invalid";
        acc(24'h002000, 1'b1); acc(24'h100000, 1'b0); acc(24'h800000, 1'b1);
        do_reset(1'b1);
        cur_req = "R7 boot window strap high";
        acc(24'h001000, 1'b1); acc(24'h000000, 1'b0);

        cur_req = "R10 base mask valid match";
        wcfg(4'd2, 32'h8010_0000); wcfg(4'd3, 32'h20FF_0000);
        acc(24'h10ABCD, 1'b1); acc(24'h110000, 1'b1); acc(24'h0FFFFF, 1'b0);
        wcfg(4'd2, 32'h0010_0000);
        acc(24'h10ABCD, 1'b1);
        wcfg(4'd2, 32'h8010_0000);

        cur_req = "R11 idle bus";
        bus_vld = 1'b0; bus_addr = 24'h100010; bus_rd = 1'b0; tick(); tick();

        wcfg(4'd4, 32'h8010_4000);
        for (int en = 0; en < 4; en++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    cur_req = "R1 R2 R3 R4 R5 overlap combinations";
                    wcfg(4'd8, 32'(en));
                    wcfg(4'd3, {a[1:0], 1'b1, 5'b0, 24'hFF0000});
                    wcfg(4'd5, {b[1:0], 1'b0, 5'b0, 24'hFFF000});
                    acc(24'h104010, 1'b1); acc(24'h104010, 1'b0);
                    acc(24'h100010, 1'b1); acc(24'h100010, 1'b0);
                    cur_req = "R2 sticky flags hold";
                    tick();
                    wcfg(4'd8, 32'h0000_0300 | 32'(en));
                end
            end
        end

        cur_req = "R6 register block quiet";
        wcfg(4'd8, 32'h0000_0003);
        wcfg(4'd3, 32'h20FF_0000);
        wcfg(4'd5, 32'h40FF_F000);
        wcfg(4'd9, 32'h0010_4000);
        acc(24'h104800, 1'b1); acc(24'h104800, 1'b0); acc(24'h104FFF, 1'b0);
        acc(24'h105000, 1'b0);
        wcfg(4'd8, 32'h0000_0303);
        wcfg(4'd9, 32'h00FF_F000);
        wcfg(4'd0, 32'h80FF_0000); wcfg(4'd1, 32'h20FF_0000);
        acc(24'hFFF010, 1'b1); acc(24'hFFF010, 1'b0); acc(24'hFF0010, 1'b1);

        cur_req = "R9 legacy bus off";
        wcfg(4'd8, 32'h0000_0300);
        wcfg(4'd6, 32'h8020_0000); wcfg(4'd7, 32'h20FF_0000);
        acc(24'h200010, 1'b1); acc(24'h200010, 1'b0);
        cur_req = "R9 legacy bus on";
        wcfg(4'd8, 32'h0000_0004);
        acc(24'h200010, 1'b1); acc(24'h200010, 1'b0); acc(24'h300000, 1'b1);
        cur_req = "R1 legacy window loses to higher priority";
        wcfg(4'd2, 32'h8020_0000);
        acc(24'h200010, 1'b1);
        tick(); tick();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule